// File: doc/BRIEF.md
# Trimmed-Mean Sample Filter

This block takes a burst of 12-bit temperature readings and reduces it to one filtered value. A measurement begins with a `start` pulse while the block is idle. The 3-bit `mode` value present on that cycle is stored, and it alone decides how many readings make up the burst and how they are combined.

Modes 0, 6 and 7 pass a single reading through unchanged. Mode 1 averages two readings. Modes 2, 3, 4 and 5 collect 4, 6, 10 and 18 readings. In those modes exactly one largest and one smallest reading are discarded, and the remaining 2, 4, 8 or 16 are averaged. The count left over is always a power of two, so the division is a right shift that rounds down.

Readings enter on a valid/ready stream. `s_ready` is high only while a burst is being collected, and a reading is taken on any clock where both `s_valid` and `s_ready` are high. The result leaves on a valid/ready stream. `r_valid` rises on the cycle after the last reading of the burst is taken. `r_valid` and `r_data` then hold steady until `r_ready` is seen high on a clock edge, after which the block returns to idle. No new readings are accepted while a result waits, so a stalled consumer stalls the producer.

Top module: `trim_mean_filter`

## Requirements
- R1: After reset, `s_ready`, `r_valid` and `busy` are all low.
- R2: In mode 0, and in modes 6 and 7, exactly one reading is taken and `r_data` equals it unchanged.
- R3: In mode 1, two readings are taken and `r_data` is their sum shifted right by one.
- R4: Modes 2, 3, 4 and 5 take 4, 6, 10 and 18 readings respectively. `r_data` is (sum − largest − smallest) shifted right by 1, 2, 3 and 4 respectively.
- R5: When several readings tie for largest or smallest, only one copy of each is removed.
- R6: The mode is sampled only on the accepted `start` cycle. Changes on `mode` during a burst have no effect on the count or on the result.
- R7: `s_ready` is high exactly while a burst is being collected. Cycles with `s_valid` low take no reading, and no reading is taken while a result waits.
- R8: `r_valid` rises on the cycle after the last reading is taken. `r_valid` and `r_data` stay stable until `r_ready` is high on a clock edge. On that edge `busy` falls.
- R9: A `start` pulse while `busy` is high is ignored.
- R10: Eighteen readings of 4095 in mode 5 give 4095, with no overflow in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a measurement when the block is idle |
| mode | input | 3 | Filter selection, sampled on the accepted start |
| busy | output | 1 | High from accepted start until the result is taken |
| s_valid | input | 1 | Reading on `s_data` is valid |
| s_ready | output | 1 | Block accepts a reading this cycle |
| s_data | input | 12 | Temperature reading |
| r_valid | output | 1 | Filtered result is available |
| r_ready | input | 1 | Consumer takes the result |
| r_data | output | 12 | Filtered result |

## Verification
The assertions assume that readings are unsigned 12-bit codes and that reset is asserted before the first burst. They also assume that `r_ready` is only meaningful while `r_valid` is high. The stimulus drives every input on the falling edge, so nothing changes near the sampling edge. It begins each burst only after the previous result has been taken, and it deliberately toggles `mode`, raises `start` and offers readings while they must be ignored. This shows that the documented stall and ignore rules hold under those inputs.

// File: rtl/tmf_pkg.sv
package tmf_pkg;

  localparam int unsigned CNT_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_HOLD = 2'd2
  } tmf_state_e;

  // readings gathered per burst for each mode
  function automatic logic [CNT_W-1:0] burst_len(input logic [2:0] m);
    case (m)
      3'd1:    burst_len = CNT_W'(2);
      3'd2:    burst_len = CNT_W'(4);
      3'd3:    burst_len = CNT_W'(6);
      3'd4:    burst_len = CNT_W'(10);
      3'd5:    burst_len = CNT_W'(18);
      default: burst_len = CNT_W'(1);
    endcase
  endfunction

  // right shift that divides by the kept count
  function automatic logic [2:0] keep_shift(input logic [2:0] m);
    case (m)
      3'd1, 3'd2: keep_shift = 3'd1;
      3'd3:       keep_shift = 3'd2;
      3'd4:       keep_shift = 3'd3;
      3'd5:       keep_shift = 3'd4;
      default:    keep_shift = 3'd0;
    endcase
  endfunction

  function automatic logic drops_extremes(input logic [2:0] m);
    drops_extremes = (m >= 3'd2) && (m <= 3'd5);
  endfunction

endpackage

// File: rtl/tmf_ctrl.sv
module tmf_ctrl
  import tmf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       mode,
  input  logic             s_valid,
  input  logic             r_ready,
  output tmf_state_e       state,
  output logic [2:0]       mode_q,
  output logic             clear,
  output logic             take
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] need;
  logic             last;

  assign need  = burst_len(mode_q);
  assign clear = (state == ST_IDLE) && start;
  assign take  = (state == ST_FILL) && s_valid;
  assign last  = take && (cnt == need - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= '0;
      cnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          mode_q <= mode;
          cnt    <= '0;
          state  <= ST_FILL;
        end
        ST_FILL: if (take) begin
          cnt <= cnt + CNT_W'(1);
          if (last) state <= ST_HOLD;
        end
        ST_HOLD: if (r_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |-> (cnt < need));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(mode_q));

endmodule

// File: rtl/tmf_stats.sv
module tmf_stats #(
  parameter int unsigned DW = 12,
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] sum,
  output logic [DW-1:0] maxv,
  output logic [DW-1:0] minv
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum  <= '0;
      maxv <= '0;
      minv <= '1;
    end else if (clear) begin
      sum  <= '0;
      maxv <= '0;
      minv <= '1;
    end else if (take) begin
      sum <= sum + AW'(din);
      if (din > maxv) maxv <= din;
      if (din < minv) minv <= din;
    end
  end

  // R10
  sum_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum >= AW'(maxv));

endmodule

// File: rtl/tmf_reduce.sv
module tmf_reduce
  import tmf_pkg::*;
#(
  parameter int unsigned DW = 12,
  parameter int unsigned AW = 17
) (
  input  logic [2:0]    mode_q,
  input  logic [AW-1:0] sum,
  input  logic [DW-1:0] maxv,
  input  logic [DW-1:0] minv,
  output logic [DW-1:0] avg
);

  logic [AW-1:0] kept;
  logic [AW-1:0] shifted;

  always_comb begin
    if (drops_extremes(mode_q)) kept = sum - AW'(maxv) - AW'(minv);
    else                        kept = sum;
    shifted = kept >> keep_shift(mode_q);
    avg     = shifted[DW-1:0];
  end

endmodule

// File: rtl/trim_mean_filter.sv
module trim_mean_filter
  import tmf_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  output logic          busy,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          r_valid,
  input  logic          r_ready,
  output logic [DW-1:0] r_data
);

  localparam int unsigned AW = DW + CNT_W;

  tmf_state_e    state;
  logic [2:0]    mode_q;
  logic          clear;
  logic          take;
  logic [AW-1:0] sum;
  logic [DW-1:0] maxv;
  logic [DW-1:0] minv;

  tmf_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .s_valid (s_valid),
    .r_ready (r_ready),
    .state   (state),
    .mode_q  (mode_q),
    .clear   (clear),
    .take    (take)
  );

  tmf_stats #(.DW(DW), .AW(AW)) u_stats (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .take  (take),
    .din   (s_data),
    .sum   (sum),
    .maxv  (maxv),
    .minv  (minv)
  );

  tmf_reduce #(.DW(DW), .AW(AW)) u_reduce (
    .mode_q (mode_q),
    .sum    (sum),
    .maxv   (maxv),
    .minv   (minv),
    .avg    (r_data)
  );

  assign busy    = (state != ST_IDLE);
  assign s_ready = (state == ST_FILL);
  assign r_valid = (state == ST_HOLD);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));

  // R4
  avg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> ((r_data <= maxv) && (r_data >= minv)));

endmodule

// File: tb/trim_mean_filter_tb.sv
module trim_mean_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        busy;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_data = '0;
  logic        r_valid;
  logic        r_ready = 1'b0;
  logic [11:0] r_data;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  trim_mean_filter u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 collecting, 2 result waiting
  int    m_st = 0;
  int    m_need = 1;
  int    m_res = 0;
  string m_tag = "R2";
  int    mq[$];

  function automatic int need_of(input int m);
    case (m)
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 10;
      5: return 18;
      default: return 1;
    endcase
  endfunction

  function automatic int reduce_q(input int n);
    int s = 0, lo = 1 << 30, hi = -1;
    foreach (mq[i]) begin
      s += mq[i];
      if (mq[i] < lo) lo = mq[i];
      if (mq[i] > hi) hi = mq[i];
    end
    if (n == 1) return s;
    if (n == 2) return s / 2;
    return (s - lo - hi) / (n - 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0;
      mq.delete();
    end else if (m_st == 0 && start) begin
      m_need = need_of(int'(mode));
      m_tag  = (m_need == 1) ? "R2" : (m_need == 2) ? "R3" : "R4";
      mq.delete();
      m_st = 1;
    end else if (m_st == 1 && s_valid) begin
      mq.push_back(int'(s_data));
      if (mq.size() == m_need) begin
        m_res = reduce_q(m_need);
        m_st  = 2;
      end
    end else if (m_st == 2 && r_ready) begin
      m_st = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 s_ready vs model", int'(s_ready), int'(m_st == 1));
      chk("R8 r_valid vs model", int'(r_valid), int'(m_st == 2));
      chk("R9 busy vs model", int'(busy), int'(m_st != 0));
      if (m_st == 2) chk({m_tag, " r_data vs model"}, int'(r_data), m_res);
    end
  end

  int stim[$];

  task automatic burst(input logic [2:0] m, input int exp, input string tag,
                       input bit gap, input bit restart);
    start = 1'b1; mode = m;
    @(negedge clk);
    start = 1'b0;
    mode = (m == 3'd5) ? 3'd0 : 3'd5;   // R6: change after start
    chk("R7 ready after start", int'(s_ready), 1);
    for (int i = 0; i < stim.size(); i++) begin
      if (gap && i == 1) begin
        s_valid = 1'b0;
        s_data  = 12'hABC;
        start   = restart;               // R9: ignored while busy
        @(negedge clk);
        start = 1'b0;
      end
      s_valid = 1'b1;
      s_data  = 12'(stim[i]);
      @(negedge clk);
    end
    s_valid = 1'b0;
    chk("R8 r_valid after last", int'(r_valid), 1);
    chk({tag, " result"}, int'(r_data), exp);
    s_valid = 1'b1; s_data = 12'd999;     // R7: offered while waiting
    @(negedge clk);
    chk("R8 held r_valid", int'(r_valid), 1);
    chk({tag, " held result"}, int'(r_data), exp);
    chk("R7 no ready while waiting", int'(s_ready), 0);
    s_valid = 1'b0;
    r_ready = 1'b1;
    @(negedge clk);
    r_ready = 1'b0;
    chk("R8 busy falls on take", int'(busy), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 s_ready", int'(s_ready), 0);
    chk("R1 r_valid", int'(r_valid), 0);
    chk("R1 busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    stim = '{1234};                       burst(3'd0, 1234, "R2", 0, 0);
    stim = '{77};                         burst(3'd7, 77, "R2", 0, 0);
    stim = '{3000};                       burst(3'd6, 3000, "R2", 0, 0);
    stim = '{10, 13};                     burst(3'd1, 11, "R3", 1, 0);
    stim = '{100, 5, 50, 60};             burst(3'd2, 55, "R4", 1, 1);
    stim = '{7, 7, 7, 1, 9, 3};           burst(3'd3, 6, "R4", 0, 0);
    stim = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10}; burst(3'd4, 5, "R4", 1, 0);
    stim = '{5, 5, 5, 5, 9, 9};           burst(3'd3, 6, "R5", 0, 0);
    stim.delete();
    for (int i = 0; i < 18; i++) stim.push_back(4095);
    burst(3'd5, 4095, "R10", 1, 1);
    stim.delete();
    for (int i = 0; i < 18; i++) stim.push_back(i * 200);
    burst(3'd5, 1700, "R4", 0, 0);
    stim = '{8, 8, 8, 8};                 burst(3'd2, 8, "R6", 1, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule